// File: doc/BRIEF.md
# Video Sync Mode Detector

This block watches a raw horizontal and a raw vertical sync signal and measures them against a 10 MHz reference clock. For each signal it counts the cycles between rising edges to obtain the period, and counts high cycles to decide polarity. It counts horizontal pulses inside each vertical frame to get the total line count. A qualifier input for each signal can declare that signal absent. When either signal is missing or too slow, the block raises a power-save request.

Measured results are committed only once a new value has been seen at two consecutive frame ends. On every commit the line count is taken again, and the committed values are looked up in a parameterised mode table. A mode is reported only when the periods and polarities match a table row and the line count also agrees with that row. The block also limits a programmed vertical display position so that it never exceeds the committed line count.

Top module: `sync_mode_detector`

## Requirements
- R1: After reset, power_save is 1, mode_valid and mode_unknown are 0, and line_count reads all ones, so vpos_out follows vpos_req unchanged.
- R2: Horizontal sync is absent, and power_save is 1, when its synchronised rising edges are H_TIMEOUT or more reference cycles apart, when edges stop, or while h_det_in is 0. A period of H_TIMEOUT-1 counts as present.
- R3: Vertical sync follows the same rules with V_TIMEOUT and v_det_in.
- R4: While power_save is 1, mode_valid is 0. Once both syncs are present again, a mode is re-established after two complete frames.
- R5: h_period and v_period report the committed number of reference cycles between consecutive rising edges of each sync.
- R6: A sync input that is high for more than half of its period is reported as negative polarity (h_neg or v_neg = 1). Otherwise it is reported as 0.
- R7: line_count is the number of horizontal rising edges between two consecutive vertical rising edges, taken at the last commit.
- R8: On a commit, the lowest-index table row is selected whose H and V periods are each within (row value >> MATCH_SHIFT) of the measurement and whose two polarities are equal to the measured ones. If that row's line count is also within LINE_TOL, mode_idx takes that row index, mode_valid is set to 1 and mode_unknown is set to 0.
- R9: On a commit with no matching row, or with a matching row whose line count disagrees, mode_unknown is set to 1 and mode_idx and mode_valid keep their previous values.
- R10: A commit happens at a frame end when the H or V period differs from the committed value by more than (committed >> CHG_SHIFT), or a polarity differs, and this was also true at the previous frame end. The commit recounts lines even if the same row is selected again. A single deviating frame changes nothing.
- R11: One cycle after any change, vpos_out equals vpos_req if vpos_req does not exceed line_count, and equals line_count otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| h_det_in | input | 1 | Horizontal presence qualifier; 0 forces absence |
| v_det_in | input | 1 | Vertical presence qualifier; 0 forces absence |
| vpos_req | input | LN_W (12) | Programmed vertical display position |
| mode_idx | output | IDX_W (clog2 NUM_MODES) | Identified table row |
| mode_valid | output | 1 | A mode has been confirmed |
| mode_unknown | output | 1 | Last commit found no confirmed row |
| power_save | output | 1 | A sync is absent |
| h_period | output | HP_W (16) | Committed horizontal period in reference cycles |
| v_period | output | VP_W (24) | Committed vertical period in reference cycles |
| h_neg | output | 1 | Committed horizontal polarity, 1 = negative |
| v_neg | output | 1 | Committed vertical polarity, 1 = negative |
| line_count | output | LN_W (12) | Committed lines per frame |
| vpos_out | output | LN_W (12) | Limited vertical position |

## Verification
The bench builds the block with H_TIMEOUT=64 and V_TIMEOUT=1024. It uses a four-row table of 16 to 24 cycle lines and 8 to 12 line frames, with MATCH_SHIFT=3, CHG_SHIFT=5 and LINE_TOL=0. These values keep frames to a few hundred cycles, which makes it affordable to sweep every table row and all four polarity pairs. They also let the bench place the two absence limits exactly at a period of 63 versus 64 and of 1008 versus 1024 cycles. With a line tolerance of zero, a single extra line already gives a frequency-matched but line-mismatched frame.

// File: rtl/syncmode_pkg.sv
package syncmode_pkg;

  localparam int HP_W = 16;
  localparam int VP_W = 24;
  localparam int LN_W = 12;
  localparam int DEF_MODES = 4;

  typedef struct packed {
    logic [HP_W-1:0] h_per;
    logic [VP_W-1:0] v_per;
    logic            h_neg;
    logic            v_neg;
    logic [LN_W-1:0] lines;
  } mode_entry_t;

  // Relative closeness: |meas - refv| <= refv >> sh
  function automatic logic near_rel(input int unsigned meas, input int unsigned refv,
                                    input int unsigned sh);
    int unsigned d;
    d = (meas > refv) ? (meas - refv) : (refv - meas);
    return d <= (refv >> sh);
  endfunction

  // Absolute closeness: |meas - refv| <= tol
  function automatic logic near_abs(input int unsigned meas, input int unsigned refv,
                                    input int unsigned tol);
    int unsigned d;
    d = (meas > refv) ? (meas - refv) : (refv - meas);
    return d <= tol;
  endfunction

  // Default table for a 10 MHz reference
  function automatic mode_entry_t [DEF_MODES-1:0] default_table();
    mode_entry_t [DEF_MODES-1:0] t;
    t[0] = '{h_per: 16'd318, v_per: 24'd166833, h_neg: 1'b1, v_neg: 1'b1, lines: 12'd525};
    t[1] = '{h_per: 16'd318, v_per: 24'd142857, h_neg: 1'b1, v_neg: 1'b0, lines: 12'd449};
    t[2] = '{h_per: 16'd264, v_per: 24'd165808, h_neg: 1'b0, v_neg: 1'b0, lines: 12'd628};
    t[3] = '{h_per: 16'd207, v_per: 24'd166804, h_neg: 1'b1, v_neg: 1'b1, lines: 12'd806};
    return t;
  endfunction

endpackage

// File: rtl/sync_meter.sv
module sync_meter #(
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic             det_in,
  output logic             meas_stb,
  output logic             present,
  output logic [CNT_W-1:0] period,
  output logic             neg
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic [1:0]       sync_ff;
  logic             s_d;
  logic             s;
  logic             rise;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hi_cnt;
  logic             seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_ff <= 2'b00;
      s_d     <= 1'b0;
    end else begin
      sync_ff <= {sync_ff[0], sync_in};
      s_d     <= sync_ff[1];
    end
  end

  assign s    = sync_ff[1];
  assign rise = s & ~s_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= LIMIT;
      hi_cnt   <= '0;
      seen     <= 1'b0;
      present  <= 1'b0;
      period   <= '0;
      neg      <= 1'b0;
      meas_stb <= 1'b0;
    end else begin
      meas_stb <= 1'b0;
      if (rise) begin
        cnt    <= CNT_W'(1);
        hi_cnt <= CNT_W'(1);
        seen   <= 1'b1;
        if (seen && cnt < LIMIT) begin
          period   <= cnt;
          neg      <= ({hi_cnt, 1'b0} > {1'b0, cnt});
          present  <= det_in;
          meas_stb <= det_in;
        end else begin
          present <= 1'b0;
        end
      end else begin
        if (cnt < LIMIT) cnt <= cnt + 1'b1;
        else             present <= 1'b0;
        if (s && hi_cnt < LIMIT) hi_cnt <= hi_cnt + 1'b1;
      end
      if (!det_in) present <= 1'b0;
    end
  end

  a_r2_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  a_r2_r3_present_after_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(present) |-> $past(rise) && $past(det_in));

endmodule

// File: rtl/line_counter.sv
module line_counter #(
  parameter int LN_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            h_stb,
  input  logic            v_stb,
  output logic [LN_W-1:0] lines,
  output logic            frame_done
);

  localparam logic [LN_W-1:0] MAXV = '1;

  logic [LN_W-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt       <= '0;
      lines      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= v_stb;
      if (v_stb) begin
        lines <= (hcnt == MAXV) ? MAXV : hcnt + LN_W'(h_stb);
        hcnt  <= '0;
      end else if (h_stb && hcnt != MAXV) begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  a_r7_lines_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(v_stb) |-> $stable(lines));

endmodule

// File: rtl/mode_matcher.sv
module mode_matcher import syncmode_pkg::*; #(
  parameter int NUM_MODES   = DEF_MODES,
  parameter int IDX_W       = 2,
  parameter int MATCH_SHIFT = 6,
  parameter int LINE_TOL    = 2,
  parameter mode_entry_t [NUM_MODES-1:0] MODE_TABLE = default_table()
) (
  input  logic [HP_W-1:0]  h_per,
  input  logic [VP_W-1:0]  v_per,
  input  logic             h_neg,
  input  logic             v_neg,
  input  logic [LN_W-1:0]  lines,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             line_ok
);

  logic [NUM_MODES-1:0] freq_ok;
  logic [NUM_MODES-1:0] lines_ok;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_row
    assign freq_ok[g] =
      near_rel(32'(h_per), 32'(MODE_TABLE[g].h_per), MATCH_SHIFT) &&
      near_rel(32'(v_per), 32'(MODE_TABLE[g].v_per), MATCH_SHIFT) &&
      (h_neg == MODE_TABLE[g].h_neg) && (v_neg == MODE_TABLE[g].v_neg);
    assign lines_ok[g] = near_abs(32'(lines), 32'(MODE_TABLE[g].lines), LINE_TOL);
  end

  // Lowest index wins: scan downward so the last hit is the lowest row
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_MODES - 1; i >= 0; i--) begin
      if (freq_ok[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign line_ok = lines_ok[idx];

endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl import syncmode_pkg::*; #(
  parameter int IDX_W     = 2,
  parameter int CHG_SHIFT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_done,
  input  logic             h_present,
  input  logic             v_present,
  input  logic [HP_W-1:0]  h_per_m,
  input  logic [VP_W-1:0]  v_per_m,
  input  logic             h_neg_m,
  input  logic             v_neg_m,
  input  logic [LN_W-1:0]  lines_m,
  input  logic             hit,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             line_ok,
  input  logic [LN_W-1:0]  vpos_req,
  output logic [IDX_W-1:0] mode_idx,
  output logic             mode_valid,
  output logic             mode_unknown,
  output logic             power_save,
  output logic [HP_W-1:0]  h_period,
  output logic [VP_W-1:0]  v_period,
  output logic             h_neg,
  output logic             v_neg,
  output logic [LN_W-1:0]  line_count,
  output logic [LN_W-1:0]  vpos_out
);

  logic absent;
  logic locked;
  logic pend;
  logic chg;

  assign absent = !(h_present && v_present);

  always_comb begin
    chg = !locked ||
          !near_rel(32'(h_per_m), 32'(h_period), CHG_SHIFT) ||
          !near_rel(32'(v_per_m), 32'(v_period), CHG_SHIFT) ||
          (h_neg_m != h_neg) || (v_neg_m != v_neg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      power_save   <= 1'b1;
      locked       <= 1'b0;
      pend         <= 1'b0;
      mode_idx     <= '0;
      mode_valid   <= 1'b0;
      mode_unknown <= 1'b0;
      h_period     <= '0;
      v_period     <= '0;
      h_neg        <= 1'b0;
      v_neg        <= 1'b0;
      line_count   <= '1;
      vpos_out     <= '0;
    end else begin
      power_save <= absent;
      vpos_out   <= (vpos_req > line_count) ? line_count : vpos_req;
      if (absent) begin
        locked       <= 1'b0;
        pend         <= 1'b0;
        mode_valid   <= 1'b0;
        mode_unknown <= 1'b0;
      end else if (frame_done) begin
        if (chg) begin
          if (pend) begin
            locked     <= 1'b1;
            pend       <= 1'b0;
            h_period   <= h_per_m;
            v_period   <= v_per_m;
            h_neg      <= h_neg_m;
            v_neg      <= v_neg_m;
            line_count <= lines_m;
            if (hit && line_ok) begin
              mode_idx     <= hit_idx;
              mode_valid   <= 1'b1;
              mode_unknown <= 1'b0;
            end else begin
              mode_unknown <= 1'b1;
            end
          end else begin
            pend <= 1'b1;
          end
        end else begin
          pend <= 1'b0;
        end
      end
    end
  end

  a_r4_save_clears_valid: assert property (@(posedge clk) disable iff (rst)
    power_save |-> !mode_valid);

  a_r8_valid_rise_known: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_valid) |-> !mode_unknown);

  a_r9_unknown_keeps_idx: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_unknown) |-> $stable(mode_idx));

  a_r10_commit_after_pending: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_count) |-> $past(pend) && $past(frame_done));

  a_r11_position_limited: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> vpos_out <= $past(line_count));

endmodule

// File: rtl/sync_mode_detector.sv
module sync_mode_detector import syncmode_pkg::*; #(
  parameter int NUM_MODES   = DEF_MODES,
  parameter int H_TIMEOUT   = 1000,
  parameter int V_TIMEOUT   = 1000000,
  parameter int MATCH_SHIFT = 6,
  parameter int CHG_SHIFT   = 7,
  parameter int LINE_TOL    = 2,
  parameter mode_entry_t [NUM_MODES-1:0] MODE_TABLE = default_table(),
  localparam int IDX_W = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             h_det_in,
  input  logic             v_det_in,
  input  logic [LN_W-1:0]  vpos_req,
  output logic [IDX_W-1:0] mode_idx,
  output logic             mode_valid,
  output logic             mode_unknown,
  output logic             power_save,
  output logic [HP_W-1:0]  h_period,
  output logic [VP_W-1:0]  v_period,
  output logic             h_neg,
  output logic             v_neg,
  output logic [LN_W-1:0]  line_count,
  output logic [LN_W-1:0]  vpos_out
);

  logic            h_stb, v_stb, h_pres, v_pres, h_neg_m, v_neg_m;
  logic [HP_W-1:0] h_per_m;
  logic [VP_W-1:0] v_per_m;
  logic [LN_W-1:0] lines_m;
  logic            frame_done;
  logic            hit, line_ok;
  logic [IDX_W-1:0] hit_idx;

  sync_meter #(.CNT_W(HP_W), .TIMEOUT(H_TIMEOUT)) u_hmeter (
    .clk(clk), .rst(rst), .sync_in(hsync_in), .det_in(h_det_in),
    .meas_stb(h_stb), .present(h_pres), .period(h_per_m), .neg(h_neg_m));

  sync_meter #(.CNT_W(VP_W), .TIMEOUT(V_TIMEOUT)) u_vmeter (
    .clk(clk), .rst(rst), .sync_in(vsync_in), .det_in(v_det_in),
    .meas_stb(v_stb), .present(v_pres), .period(v_per_m), .neg(v_neg_m));

  line_counter #(.LN_W(LN_W)) u_lines (
    .clk(clk), .rst(rst), .h_stb(h_stb), .v_stb(v_stb),
    .lines(lines_m), .frame_done(frame_done));

  mode_matcher #(
    .NUM_MODES(NUM_MODES), .IDX_W(IDX_W), .MATCH_SHIFT(MATCH_SHIFT),
    .LINE_TOL(LINE_TOL), .MODE_TABLE(MODE_TABLE)
  ) u_match (
    .h_per(h_per_m), .v_per(v_per_m), .h_neg(h_neg_m), .v_neg(v_neg_m),
    .lines(lines_m), .hit(hit), .idx(hit_idx), .line_ok(line_ok));

  mode_ctrl #(.IDX_W(IDX_W), .CHG_SHIFT(CHG_SHIFT)) u_ctrl (
    .clk(clk), .rst(rst), .frame_done(frame_done),
    .h_present(h_pres), .v_present(v_pres),
    .h_per_m(h_per_m), .v_per_m(v_per_m), .h_neg_m(h_neg_m), .v_neg_m(v_neg_m),
    .lines_m(lines_m), .hit(hit), .hit_idx(hit_idx), .line_ok(line_ok),
    .vpos_req(vpos_req),
    .mode_idx(mode_idx), .mode_valid(mode_valid), .mode_unknown(mode_unknown),
    .power_save(power_save), .h_period(h_period), .v_period(v_period),
    .h_neg(h_neg), .v_neg(v_neg), .line_count(line_count), .vpos_out(vpos_out));

endmodule

// File: tb/sync_mode_detector_test.sv
module sync_mode_detector_test;
  import syncmode_pkg::*;

  function automatic mode_entry_t [3:0] tb_table();
    mode_entry_t [3:0] t;
    t[0] = '{h_per: 16'd20, v_per: 24'd200, h_neg: 1'b1, v_neg: 1'b1, lines: 12'd10};
    t[1] = '{h_per: 16'd16, v_per: 24'd192, h_neg: 1'b0, v_neg: 1'b0, lines: 12'd12};
    t[2] = '{h_per: 16'd20, v_per: 24'd200, h_neg: 1'b1, v_neg: 1'b0, lines: 12'd10};
    t[3] = '{h_per: 16'd24, v_per: 24'd192, h_neg: 1'b0, v_neg: 1'b1, lines: 12'd8};
    return t;
  endfunction

  localparam mode_entry_t [3:0] TB_TABLE = tb_table();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_in = 1'b0, vsync_in = 1'b0;
  logic h_det_in = 1'b1, v_det_in = 1'b1;
  logic [LN_W-1:0] vpos_req = 12'd7;
  logic [1:0]      mode_idx;
  logic            mode_valid, mode_unknown, power_save, h_neg, v_neg;
  logic [HP_W-1:0] h_period;
  logic [VP_W-1:0] v_period;
  logic [LN_W-1:0] line_count, vpos_out;

  sync_mode_detector #(
    .NUM_MODES(4), .H_TIMEOUT(64), .V_TIMEOUT(1024), .MATCH_SHIFT(3),
    .CHG_SHIFT(5), .LINE_TOL(0), .MODE_TABLE(TB_TABLE)
  ) uut (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .h_det_in(h_det_in), .v_det_in(v_det_in), .vpos_req(vpos_req),
    .mode_idx(mode_idx), .mode_valid(mode_valid), .mode_unknown(mode_unknown),
    .power_save(power_save), .h_period(h_period), .v_period(v_period),
    .h_neg(h_neg), .v_neg(v_neg), .line_count(line_count), .vpos_out(vpos_out));

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  // Stimulus settings
  int g_hper = 20, g_lines = 10, glitch_req = 0;
  bit g_hneg = 1'b1, g_vneg = 1'b1, g_hen = 1'b1, g_ven = 1'b1;

  // Sync generator: 4-cycle H pulse, 2-line V pulse
  initial begin
    int hc = 0;
    int vc = 7;
    int vper = 200;
    int gdone = 0;
    forever begin
      @(negedge clk);
      hc = (hc + 1 >= g_hper) ? 0 : hc + 1;
      if (vc + 1 >= vper) begin
        vc = 0;
        vper = g_lines * g_hper;
        if (gdone != glitch_req) begin
          vper = vper + g_hper;
          gdone = glitch_req;
        end
      end else begin
        vc = vc + 1;
      end
      hsync_in = g_hen ? ((hc < 4) ^ g_hneg) : g_hneg;
      vsync_in = g_ven ? ((vc < 2 * g_hper) ^ g_vneg) : g_vneg;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_sig(input int hp, input int ln, input bit hn, input bit vn);
    g_hper = hp; g_lines = ln; g_hneg = hn; g_vneg = vn;
  endtask

  task automatic settle();
    repeat (8 * g_lines * g_hper + 200) @(negedge clk);
  endtask

  task automatic expect_mode(input string tag, input int idx, input int hp, input int ln,
                             input bit hn, input bit vn);
    chk({tag, " R8 mode_idx"}, int'(mode_idx), idx);
    chk({tag, " R8 mode_valid"}, int'(mode_valid), 1);
    chk({tag, " R8 mode_unknown"}, int'(mode_unknown), 0);
    chk({tag, " R4 power_save"}, int'(power_save), 0);
    chk({tag, " R5 h_period"}, int'(h_period), hp);
    chk({tag, " R5 v_period"}, int'(v_period), hp * ln);
    chk({tag, " R7 line_count"}, int'(line_count), ln);
    chk({tag, " R6 h_neg"}, int'(h_neg), int'(hn));
    chk({tag, " R6 v_neg"}, int'(v_neg), int'(vn));
  endtask

  task automatic expect_unknown(input string tag, input int keep_idx, input int ln);
    chk({tag, " R9 mode_unknown"}, int'(mode_unknown), 1);
    chk({tag, " R9 mode_idx kept"}, int'(mode_idx), keep_idx);
    chk({tag, " R9 mode_valid kept"}, int'(mode_valid), 1);
    chk({tag, " R7 line_count"}, int'(line_count), ln);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 power_save", int'(power_save), 1);
    chk("R1 mode_valid", int'(mode_valid), 0);
    chk("R1 mode_unknown", int'(mode_unknown), 0);
    chk("R1 line_count", int'(line_count), 4095);
    chk("R1 R11 vpos passthrough", int'(vpos_out), 7);

    // Sweep every table row
    for (int m = 0; m < 4; m++) begin
      set_sig(int'(TB_TABLE[m].h_per), int'(TB_TABLE[m].lines),
              TB_TABLE[m].h_neg, TB_TABLE[m].v_neg);
      settle();
      expect_mode($sformatf("row%0d", m), m, int'(TB_TABLE[m].h_per),
                  int'(TB_TABLE[m].lines), TB_TABLE[m].h_neg, TB_TABLE[m].v_neg);
    end

    // Polarity sweep on a 20-cycle, 10-line signal (R6, R8, R9)
    set_sig(20, 10, 1'b0, 1'b0); settle();
    expect_unknown("pol00", 3, 10);
    set_sig(20, 10, 1'b1, 1'b0); settle();
    expect_mode("pol10", 2, 20, 10, 1'b1, 1'b0);
    set_sig(20, 10, 1'b0, 1'b1); settle();
    expect_unknown("pol01", 2, 10);
    chk("pol01 R6 h_neg", int'(h_neg), 0);
    chk("pol01 R6 v_neg", int'(v_neg), 1);
    set_sig(20, 10, 1'b1, 1'b1); settle();
    expect_mode("pol11", 0, 20, 10, 1'b1, 1'b1);

    // R8/R9: frequency matches row 0 but line count is 11
    set_sig(16, 12, 1'b0, 1'b0); settle();
    expect_mode("row1 again", 1, 16, 12, 1'b0, 1'b0);
    set_sig(20, 11, 1'b1, 1'b1); settle();
    expect_unknown("line mismatch", 1, 11);

    // R9: no frequency match at all
    set_sig(30, 10, 1'b0, 1'b0); settle();
    expect_unknown("no freq match", 1, 10);
    chk("no freq match R5 h_period", int'(h_period), 30);

    // R11 clamp and R10 recount
    set_sig(20, 10, 1'b1, 1'b1); settle();
    expect_mode("clamp base", 0, 20, 10, 1'b1, 1'b1);
    vpos_req = 12'd15; repeat (3) @(negedge clk);
    chk("R11 clamp above", int'(vpos_out), 10);
    vpos_req = 12'd10; repeat (3) @(negedge clk);
    chk("R11 equal passes", int'(vpos_out), 10);
    vpos_req = 12'd9; repeat (3) @(negedge clk);
    chk("R11 below passes", int'(vpos_out), 9);
    vpos_req = 12'd15;
    set_sig(20, 11, 1'b1, 1'b1); settle();
    chk("R10 recount line_count", int'(line_count), 11);
    chk("R10 R11 clamp after recount", int'(vpos_out), 11);

    // R10: period change within the same row forces a recount
    set_sig(20, 10, 1'b1, 1'b1); settle();
    set_sig(21, 10, 1'b1, 1'b1); settle();
    expect_mode("R10 same row", 0, 21, 10, 1'b1, 1'b1);

    // R10: one deviating frame is ignored
    glitch_req = glitch_req + 1;
    settle();
    chk("R10 glitch v_period", int'(v_period), 210);
    chk("R10 glitch line_count", int'(line_count), 10);
    chk("R10 glitch unknown", int'(mode_unknown), 0);
    chk("R10 glitch vpos", int'(vpos_out), 10);

    // R2/R4: H stops, then returns
    set_sig(20, 10, 1'b1, 1'b1); settle();
    g_hen = 1'b0;
    repeat (100) @(negedge clk);
    chk("R2 h stopped power_save", int'(power_save), 1);
    chk("R4 h stopped mode_valid", int'(mode_valid), 0);
    g_hen = 1'b1; settle();
    expect_mode("R4 reacquire", 0, 20, 10, 1'b1, 1'b1);

    // R2: qualifier low
    h_det_in = 1'b0; repeat (4) @(negedge clk);
    chk("R2 h_det low power_save", int'(power_save), 1);
    h_det_in = 1'b1; settle();
    chk("R2 h_det restored", int'(power_save), 0);

    // R2 boundary: period 64 absent, 63 present
    set_sig(64, 3, 1'b0, 1'b0); settle();
    chk("R2 period 64 absent", int'(power_save), 1);
    set_sig(63, 3, 1'b0, 1'b0); settle();
    chk("R2 period 63 present", int'(power_save), 0);
    chk("R2 R5 period 63", int'(h_period), 63);

    // R3: V stops, qualifier, boundary
    set_sig(20, 10, 1'b1, 1'b1); settle();
    g_ven = 1'b0;
    repeat (1200) @(negedge clk);
    chk("R3 v stopped power_save", int'(power_save), 1);
    g_ven = 1'b1; settle();
    chk("R3 v restored", int'(power_save), 0);
    v_det_in = 1'b0; repeat (4) @(negedge clk);
    chk("R3 v_det low power_save", int'(power_save), 1);
    v_det_in = 1'b1;
    set_sig(16, 64, 1'b0, 1'b0); settle();
    chk("R3 frame 1024 absent", int'(power_save), 1);
    set_sig(16, 63, 1'b0, 1'b0); settle();
    chk("R3 frame 1008 present", int'(power_save), 0);
    chk("R3 R7 63 lines", int'(line_count), 63);
    chk("R3 R5 v_period 1008", int'(v_period), 1008);

    finish_run();
  end

endmodule